// File: doc/BRIEF.md
# Burst Transfer Sequencer for a Shared-Bus Memory Slave

This block sits on the slave side of a single shared bus. Once an external arbiter has granted the bus, the winning master presents one burst request: a start word address, a length code and a read/write flag. The sequencer captures that request and takes the transfer through a fixed series of phases towards a simple synchronous memory. It drives the memory's chip select, write enable and word address, and marks each finished word with a one-cycle beat strobe.

The memory's timing is given by two latencies, both sampled when the request is accepted. The start-up latency is paid once at the start of every burst. The word latency is paid again for every word. The sequencer holds the bus busy for the whole burst and has at most one transfer in flight. In the final phase it raises a one-cycle done pulse, so the arbiter can grant the bus again on the following edge.

Phases, in the order they are visited: `PH_IDLE` (waiting), `PH_ARB` (grant cycle), `PH_ADDR` (start address presented), `PH_INIT` (burst start-up wait), `PH_XFER` (word-by-word transfer), `PH_LAST` (final-data cycle with done). The transitions are as follows:
- IDLE→ARB when a request is valid.
- ARB→ADDR always.
- ADDR→INIT when the start-up latency is non-zero, otherwise ADDR→XFER.
- INIT→XFER when the start-up count expires.
- XFER→LAST when the last word's latency expires.
- LAST→IDLE always.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `mem_cs`, `mem_we`, `beat_valid` and `done` are all 0.
- R2: In idle, a clock edge with `req_valid` high accepts the request and captures its fields. The cycle after that edge is the arbitration phase (`busy`=1, `mem_cs`=0). The cycle after that is the address phase, in which `mem_cs`=1 and `mem_addr` equals the captured start address.
- R3: After the address phase, the start-up phase lasts exactly `init_lat` cycles, and is skipped when `init_lat` is 0. The transfer phase follows. `mem_cs` is high from the address phase through the last transfer cycle, and low in the arbitration, final and idle cycles.
- R4: Each word takes `word_lat` cycles. `beat_valid` is high only on the last cycle of each word, and exactly as many beats occur as the burst has words.
- R5: The length code `req_len` selects the burst length: 0 gives 1 word, 1 gives 4, 2 gives 8 and 3 gives 16.
- R6: On the k-th beat (counting from 0), `mem_addr` equals the start address plus k, modulo 2^ADDR_W. Between beats the address holds its value.
- R7: `done` is high for exactly one cycle. That cycle follows the last beat, with `busy` still high, and `busy` is low in the cycle after it.
- R8: `busy` stays high for exactly 3 + `init_lat` + length × `word_lat` cycles per transfer.
- R9: `mem_we` equals the captured `req_write` while `mem_cs` is high, and is 0 otherwise.
- R10: Changes to `req_valid`, `req_addr`, `req_len` and `req_write` while `busy` is high have no effect on the transfer in progress.
- R11: A `word_lat` of 0 is treated as 1.
- R12: Changes to `init_lat` and `word_lat` after acceptance have no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Granted master presents a burst request |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | 2 | Burst length code (1/4/8/16 words) |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| init_lat | input | LAT_W | Burst start-up latency in cycles |
| word_lat | input | LAT_W | Per-word access latency in cycles |
| busy | output | 1 | A transfer is in progress; bus held |
| mem_cs | output | 1 | Memory chip select |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| beat_valid | output | 1 | One word completes this cycle |
| done | output | 1 | Final-data cycle; bus may be re-granted |

## Verification
Cycles are counted from the edge that accepts a request. The arbitration phase is cycle 0 and the address phase is cycle 1. The beat for word k falls in cycle 2 + `init_lat` + (k+1)·`word_lat` − 1, and `done` falls in cycle 2 + `init_lat` + length·`word_lat`. The bench drives inputs on falling edges and samples every output on every falling edge after acceptance. It compares each output with these arithmetic positions, and checks the idle cycle after done as well. The sweep covers every length code, start-up latencies 0 to 2 and word latencies 1, 2, 3 and 5 for both directions. Further runs change the request and latency inputs in the middle of a burst, start a burst near the top of the address space, and use a word latency of 0.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARB,
        PH_ADDR,
        PH_INIT,
        PH_XFER,
        PH_LAST
    } phase_e;

    localparam int MAX_BEATS = 16;
    localparam int BEAT_W    = $clog2(MAX_BEATS);

    // length code -> number of words minus one
    function automatic logic [BEAT_W-1:0] beats_minus1(input logic [1:0] code);
        logic [BEAT_W-1:0] r;
        unique case (code)
            2'd0:    r = BEAT_W'(0);
            2'd1:    r = BEAT_W'(3);
            2'd2:    r = BEAT_W'(7);
            default: r = BEAT_W'(MAX_BEATS - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic init_zero,
    input  logic cnt_zero,
    input  logic last_word,
    output logic busy,
    output logic mem_cs,
    output logic done,
    output logic beat,
    output logic cap_req,
    output logic addr_load,
    output logic load_init,
    output logic load_word,
    output logic advance
);

    phase_e state, state_nx;

    // next-phase selection
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE: if (req_valid) state_nx = PH_ARB;
            PH_ARB:  state_nx = PH_ADDR;
            PH_ADDR: state_nx = init_zero ? PH_XFER : PH_INIT;
            PH_INIT: if (cnt_zero) state_nx = PH_XFER;
            PH_XFER: if (cnt_zero && last_word) state_nx = PH_LAST;
            PH_LAST: state_nx = PH_IDLE;
            default: state_nx = PH_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nx;
    end

    // decoded outputs and datapath strobes
    always_comb begin
        busy      = 1'b1;
        mem_cs    = 1'b0;
        done      = 1'b0;
        beat      = 1'b0;
        cap_req   = 1'b0;
        addr_load = 1'b0;
        load_init = 1'b0;
        load_word = 1'b0;
        advance   = 1'b0;
        unique case (state)
            PH_IDLE: begin
                busy    = 1'b0;
                cap_req = req_valid;
            end
            PH_ARB: addr_load = 1'b1;
            PH_ADDR: begin
                mem_cs    = 1'b1;
                load_init = !init_zero;
                load_word = init_zero;
            end
            PH_INIT: begin
                mem_cs    = 1'b1;
                load_word = cnt_zero;
            end
            PH_XFER: begin
                mem_cs    = 1'b1;
                beat      = cnt_zero;
                load_word = cnt_zero && !last_word;
                advance   = cnt_zero && !last_word;
            end
            PH_LAST: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // R7: completion strobe never lasts two cycles
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: once started, the bus is held until the done cycle
    p_hold_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3: a word beat and the final cycle never coincide
    p_beat_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, beat}));

endmodule

// File: rtl/burst_seq_latcnt.sv
module burst_seq_latcnt #(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_req,
    input  logic [LAT_W-1:0] init_lat,
    input  logic [LAT_W-1:0] word_lat,
    input  logic             load_init,
    input  logic             load_word,
    output logic             init_zero,
    output logic             cnt_zero
);

    logic [LAT_W-1:0] init_q, word_q, cnt;

    // latencies frozen at acceptance; a zero word latency becomes one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            word_q <= LAT_W'(1);
        end else if (cap_req) begin
            init_q <= init_lat;
            word_q <= (word_lat == '0) ? LAT_W'(1) : word_lat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load_init)  cnt <= init_q - LAT_W'(1);
        else if (load_word)  cnt <= word_q - LAT_W'(1);
        else if (cnt != '0)  cnt <= cnt - LAT_W'(1);
    end

    assign init_zero = (init_q == '0);
    assign cnt_zero  = (cnt == '0);

    // R11: a word-latency reload never leaves the counter above the captured limit
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_word |=> (cnt < word_q));

endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    input  logic              req_write,
    input  logic              addr_load,
    input  logic              advance,
    input  logic              mem_cs,
    input  logic              beat,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              last_word
);

    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] len_m1_q, left_q;
    logic              we_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            len_m1_q <= '0;
            we_q     <= 1'b0;
        end else if (cap_req) begin
            start_q  <= req_addr;
            len_m1_q <= beats_minus1(req_len);
            we_q     <= req_write;
        end
    end

    // word address and remaining-word count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            left_q   <= '0;
        end else if (addr_load) begin
            mem_addr <= start_q;
            left_q   <= len_m1_q;
        end else if (advance) begin
            mem_addr <= mem_addr + ADDR_W'(1);
            left_q   <= left_q - BEAT_W'(1);
        end
    end

    assign last_word = (left_q == '0);
    assign mem_we    = mem_cs && we_q;

    // R6: the address only moves at a word boundary
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs && !beat) |=> $stable(mem_addr));

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    input  logic              req_write,
    input  logic [LAT_W-1:0]  init_lat,
    input  logic [LAT_W-1:0]  word_lat,
    output logic              busy,
    output logic              mem_cs,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat_valid,
    output logic              done
);

    logic init_zero, cnt_zero, last_word;
    logic cap_req, addr_load, load_init, load_word, advance;

    burst_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .init_zero (init_zero),
        .cnt_zero  (cnt_zero),
        .last_word (last_word),
        .busy      (busy),
        .mem_cs    (mem_cs),
        .done      (done),
        .beat      (beat_valid),
        .cap_req   (cap_req),
        .addr_load (addr_load),
        .load_init (load_init),
        .load_word (load_word),
        .advance   (advance)
    );

    burst_seq_latcnt #(.LAT_W(LAT_W)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_req   (cap_req),
        .init_lat  (init_lat),
        .word_lat  (word_lat),
        .load_init (load_init),
        .load_word (load_word),
        .init_zero (init_zero),
        .cnt_zero  (cnt_zero)
    );

    burst_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_req   (cap_req),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_write (req_write),
        .addr_load (addr_load),
        .advance   (advance),
        .mem_cs    (mem_cs),
        .beat      (beat_valid),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .last_word (last_word)
    );

    // R1: nothing reaches the memory while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_cs && !mem_we && !beat_valid));

endmodule

// File: tb/tb_burst_seq_top.sv
module tb_burst_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int LAT_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_len;
    logic              req_write;
    logic [LAT_W-1:0]  init_lat, word_lat;
    logic              busy, mem_cs, mem_we, beat_valid, done;
    logic [ADDR_W-1:0] mem_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_seq_top #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .init_lat(init_lat),
        .word_lat(word_lat), .busy(busy), .mem_cs(mem_cs), .mem_we(mem_we),
        .mem_addr(mem_addr), .beat_valid(beat_valid), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // one burst; called and returns on a falling edge
    task automatic run_xfer(input string lbl, input logic [ADDR_W-1:0] a,
                            input logic [1:0] code, input logic we,
                            input int il, input int wl, input bit disturb);
        int len, wle, total, xs, off, bidx;
        bit exp_beat;
        len   = (code == 2'd0) ? 1 : (code == 2'd1) ? 4 : (code == 2'd2) ? 8 : 16;
        wle   = (wl == 0) ? 1 : wl;
        total = 3 + il + len * wle;
        xs    = 2 + il;
        req_valid = 1'b1; req_addr = a; req_len = code; req_write = we;
        init_lat  = LAT_W'(il); word_lat = LAT_W'(wl);
        @(negedge clk);
        for (int idx = 0; idx <= total; idx++) begin
            exp_beat = 1'b0;
            bidx = 0;
            if (idx >= xs && idx < xs + len * wle) begin
                off = idx - xs;
                exp_beat = ((off % wle) == wle - 1);
                bidx = off / wle;
            end
            chk($sformatf("%s R8 busy c%0d", lbl, idx), 32'(busy), 32'(idx < total));
            chk($sformatf("%s R7 done c%0d", lbl, idx), 32'(done), 32'(idx == total - 1));
            chk($sformatf("%s R4 beat c%0d", lbl, idx), 32'(beat_valid), 32'(exp_beat));
            chk($sformatf("%s R3 mem_cs c%0d", lbl, idx), 32'(mem_cs),
                32'(idx >= 1 && idx <= total - 2));
            chk($sformatf("%s R9 we c%0d", lbl, idx), 32'(mem_we),
                32'(we && idx >= 1 && idx <= total - 2));
            if (idx == 1)
                chk($sformatf("%s R2 start addr", lbl), 32'(mem_addr), 32'(a));
            if (exp_beat)
                chk($sformatf("%s R6 addr beat%0d", lbl, bidx), 32'(mem_addr),
                    32'(ADDR_W'(a + ADDR_W'(bidx))));
            if (!disturb && idx == 0) req_valid = 1'b0;
            if (disturb && idx == 1) begin
                // R10 R12: mid-burst changes must not matter
                req_addr  = ~a; req_len = ~code; req_write = ~we;
                init_lat  = ~LAT_W'(il); word_lat = ~LAT_W'(wl);
            end
            if (disturb && idx == 2) req_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int ils[3];
        int wls[4];
        ils = '{0, 1, 2};
        wls = '{1, 2, 3, 5};
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0;
        req_write = 1'b0; init_lat = '0; word_lat = LAT_W'(1);
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset cs", 32'(mem_cs), 32'd0);
        chk("R1 reset beat", 32'(beat_valid), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle busy", 32'(busy), 32'd0);
        chk("R1 idle we", 32'(mem_we), 32'd0);

        // R5 sweep of length codes, start-up and word latencies, direction
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 3; i++)
                for (int w = 0; w < 4; w++)
                    for (int d = 0; d < 2; d++)
                        run_xfer("R5 sweep", ADDR_W'(16'h0100 + c * 64 + w), 2'(c),
                                 d[0], ils[i], wls[w], 1'b0);

        run_xfer("R10 R12 disturb", 16'h1234, 2'd2, 1'b1, 2, 3, 1'b1);
        run_xfer("R10 R12 disturb short", 16'h00F0, 2'd0, 1'b0, 0, 1, 1'b1);
        run_xfer("R6 wrap", 16'hFFFE, 2'd1, 1'b0, 1, 2, 1'b0);
        run_xfer("R11 zero word lat", 16'h0040, 2'd1, 1'b1, 1, 0, 1'b0);
        run_xfer("R2 back to back", 16'h0007, 2'd3, 1'b0, 1, 2, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule